// File: doc/BRIEF.md
# Video Test Pattern Generator

This block sits on the pixel output path. Each pixel clock it forwards one 12-bit code. That code is either the live sensor pixel or a ramp that the block makes itself. The ramp is paced by the incoming frame-valid and line-valid strobes, which the block also passes on. A 2-bit mode input picks what goes downstream.

In the fixed ramp mode, every line of every frame starts at code 960 and rises by one per pixel, so a line of the default length ends at 2008. In the sliding ramp mode, the first frame looks the same as the fixed ramp. Each later frame then moves the line's starting code up by two, and codes wrap modulo 4096. The generated codes bypass any gain or offset stage; only output formatting downstream applies to them. All outputs are registered, one cycle after the inputs they follow.

Top module: `vtpg_top`

## Requirements
- R1: With mode 0 (live) or mode 3 (reserved), pix_o equals video_i of the previous cycle.
- R2: lval_o and fval_o equal lval_i and fval_i of the previous cycle in every mode.
- R3: With mode 1 (fixed ramp), pixel k of a line (k from 0, counted from the first cycle lval_i is high) comes out as 960 + k on every line of every frame. With the default LINE_PIX of 1049, the last pixel is 2008.
- R4: If line-valid stays high beyond LINE_PIX pixels, the pixel index holds at LINE_PIX-1, so the ramp holds its last code.
- R5: In modes 1 and 2, pix_o is 0 for any cycle in which lval_i was low.
- R6: With mode 2 (sliding ramp), the first frame whose frame-valid rises after the mode is entered starts its lines at 960. Each later frame-valid rising edge raises the start code by 2. Lines are expected to begin at least one cycle after frame-valid rises.
- R7: Ramp codes wrap modulo 4096: a line starting at 4094 gives 4094, 4095, 0, 1.
- R8: Leaving mode 2, even for one cycle, returns the start code to 960, and the next sliding frame starts at 960 again.
- R9: While rst_ni is low, pix_o, lval_o and fval_o are 0, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | 0 live, 1 fixed ramp, 2 sliding ramp, 3 reserved (live) |
| fval_i | input | 1 | Frame-valid from sensor timing |
| lval_i | input | 1 | Line-valid from sensor timing |
| video_i | input | 12 | Sensor pixel code |
| pix_o | output | 12 | Selected pixel code, registered |
| lval_o | output | 1 | Line-valid, delayed one cycle |
| fval_o | output | 1 | Frame-valid, delayed one cycle |

## Verification
The assertions check, on every cycle, the rules that hold locally:
- the live pass-through;
- the one-cycle delay on the valid strobes;
- blanking outside a line;
- the bound and hold of the pixel index;
- the first-pixel code in fixed mode;
- the start register, which either steps by exactly two on an armed frame edge, stays still, or returns home when sliding mode is left.

Only the bench's scenarios can show the behaviour that spans many cycles:
- the full ramp shape across a line;
- the repeat of that shape over lines and frames;
- the "first sliding frame is unshifted" rule;
- the modulo wrap after more than a thousand frames.

// File: rtl/vtpg_pkg.sv
package vtpg_pkg;
  localparam int PIX_W = 12;

  typedef enum logic [1:0] {
    MODE_LIVE  = 2'd0,
    MODE_FIXED = 2'd1,
    MODE_SLIDE = 2'd2,
    MODE_RSVD  = 2'd3
  } mode_e;

  localparam logic [PIX_W-1:0] RAMP_BASE  = 12'd960;
  localparam logic [PIX_W-1:0] SLIDE_STEP = 12'd2;
endpackage

// File: rtl/vtpg_col_cnt.sv
module vtpg_col_cnt #(
  parameter int LINE_PIX = 1049,
  parameter int CW       = (LINE_PIX > 1) ? $clog2(LINE_PIX) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lval_i,
  output logic [CW-1:0] col_o
);
  localparam logic [CW-1:0] LAST = CW'(LINE_PIX - 1);

  logic [CW-1:0] col_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            col_q <= '0;
    else if (!lval_i)       col_q <= '0;
    else if (col_q != LAST) col_q <= col_q + 1'b1;
  end

  assign col_o = col_q;

  assert_col_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_q <= LAST);
  assert_col_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lval_i && col_q == LAST) |=> (col_q == LAST));
  assert_col_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lval_i |=> (col_q == '0));
endmodule

// File: rtl/vtpg_start_reg.sv
module vtpg_start_reg
  import vtpg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             slide_i,
  input  logic             fval_i,
  output logic [PIX_W-1:0] start_o
);
  logic             fval_d;
  logic             armed_q;
  logic [PIX_W-1:0] start_q;
  logic             f_rise;

  assign f_rise = fval_i && !fval_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fval_d  <= 1'b0;
      armed_q <= 1'b0;
      start_q <= RAMP_BASE;
    end else begin
      fval_d <= fval_i;
      if (!slide_i) begin
        armed_q <= 1'b0;
        start_q <= RAMP_BASE;
      end else if (f_rise) begin
        // first frame in sliding mode keeps the base code
        if (armed_q) start_q <= start_q + SLIDE_STEP;
        else         armed_q <= 1'b1;
      end
    end
  end

  assign start_o = start_q;

  assert_start_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slide_i && f_rise && armed_q) |=> (start_q == PIX_W'($past(start_q) + SLIDE_STEP)));
  assert_start_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slide_i && !(f_rise && armed_q)) |=> $stable(start_q));
  assert_start_home_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slide_i |=> (start_q == RAMP_BASE));
endmodule

// File: rtl/vtpg_out_mux.sv
module vtpg_out_mux
  import vtpg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gen_en_i,
  input  logic             lval_i,
  input  logic             fval_i,
  input  logic [PIX_W-1:0] video_i,
  input  logic [PIX_W-1:0] ramp_i,
  output logic [PIX_W-1:0] pix_o,
  output logic             lval_o,
  output logic             fval_o
);
  logic [PIX_W-1:0] pix_d;

  always_comb begin
    if (!gen_en_i)   pix_d = video_i;
    else if (lval_i) pix_d = ramp_i;
    else             pix_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_o  <= '0;
      lval_o <= 1'b0;
      fval_o <= 1'b0;
    end else begin
      pix_o  <= pix_d;
      lval_o <= lval_i;
      fval_o <= fval_i;
    end
  end

  assert_live_pass_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gen_en_i |=> (pix_o == $past(video_i)));
  assert_lval_delay_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (lval_o == $past(lval_i)));
  assert_fval_delay_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (fval_o == $past(fval_i)));
  assert_blank_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gen_en_i && !lval_i) |=> (pix_o == '0));
endmodule

// File: rtl/vtpg_top.sv
module vtpg_top
  import vtpg_pkg::*;
#(
  parameter int LINE_PIX = 1049
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [1:0]              mode_i,
  input  logic                    fval_i,
  input  logic                    lval_i,
  input  logic [vtpg_pkg::PIX_W-1:0] video_i,
  output logic [vtpg_pkg::PIX_W-1:0] pix_o,
  output logic                    lval_o,
  output logic                    fval_o
);
  localparam int CW = (LINE_PIX > 1) ? $clog2(LINE_PIX) : 1;

  mode_e            mode;
  logic             gen_en;
  logic             slide;
  logic [CW-1:0]    col;
  logic [PIX_W-1:0] start;
  logic [PIX_W-1:0] ramp;

  assign mode   = mode_e'(mode_i);
  assign gen_en = (mode == MODE_FIXED) || (mode == MODE_SLIDE);
  assign slide  = (mode == MODE_SLIDE);
  assign ramp   = start + PIX_W'(col);  // wraps modulo 2**PIX_W

  vtpg_col_cnt #(.LINE_PIX(LINE_PIX), .CW(CW)) u_col (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lval_i (lval_i),
    .col_o  (col)
  );

  vtpg_start_reg u_start (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .slide_i (slide),
    .fval_i  (fval_i),
    .start_o (start)
  );

  vtpg_out_mux u_mux (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .gen_en_i (gen_en),
    .lval_i   (lval_i),
    .fval_i   (fval_i),
    .video_i  (video_i),
    .ramp_i   (ramp),
    .pix_o    (pix_o),
    .lval_o   (lval_o),
    .fval_o   (fval_o)
  );

  assert_fixed_first_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_FIXED && lval_i && col == '0) |=> (pix_o == RAMP_BASE));
endmodule

// File: tb/sim_vtpg_top.sv
module sim_vtpg_top;
  localparam int LP   = 1049;
  localparam int BASE = 960;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        fval = 1'b0;
  logic        lval = 1'b0;
  logic [11:0] video = 12'h000;
  logic [11:0] pix;
  logic        lo, fo;

  int checks = 0;
  int errs   = 0;
  bit done   = 1'b0;
  logic [1:0] cur_mode = 2'd0;

  always #10 clk = ~clk;

  vtpg_top #(.LINE_PIX(LP)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .fval_i(fval), .lval_i(lval),
    .video_i(video), .pix_o(pix), .lval_o(lo), .fval_o(fo)
  );

  // {mode, fval, lval, video, exp_pix, exp_lval, exp_fval}
  localparam logic [29:0] VEC [8] = '{
    {2'd0, 1'b1, 1'b1, 12'h123, 12'h123, 1'b1, 1'b1},
    {2'd0, 1'b1, 1'b0, 12'hFFF, 12'hFFF, 1'b0, 1'b1},
    {2'd0, 1'b0, 1'b0, 12'h000, 12'h000, 1'b0, 1'b0},
    {2'd3, 1'b1, 1'b1, 12'hA5A, 12'hA5A, 1'b1, 1'b1},
    {2'd3, 1'b0, 1'b1, 12'h3C0, 12'h3C0, 1'b1, 1'b0},
    {2'd0, 1'b0, 1'b1, 12'h801, 12'h801, 1'b1, 1'b0},
    {2'd3, 1'b1, 1'b0, 12'h07F, 12'h07F, 1'b0, 1'b1},
    {2'd0, 1'b1, 1'b1, 12'hBEE, 12'hBEE, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive, then sample at the next falling edge (one register of latency)
  task automatic cyc(input logic [1:0] m, input logic f, input logic l, input logic [11:0] v);
    mode = m; fval = f; lval = l; video = v;
    @(negedge clk);
  endtask

  task automatic run_line(input int n, input int st);
    for (int k = 0; k < n; k++) begin
      cyc(cur_mode, 1'b1, 1'b1, 12'h5A5);
      if (k < LP) chk("R3/R6/R7 ramp", int'(pix), (st + k) % 4096);
      else        chk("R4 hold",       int'(pix), (st + LP - 1) % 4096);
    end
    cyc(cur_mode, 1'b1, 1'b0, 12'h5A5);
    chk("R5 blank", int'(pix), 0);
  endtask

  task automatic frame_open;
    cyc(cur_mode, 1'b1, 1'b0, 12'h000);
  endtask

  task automatic frame_close;
    cyc(cur_mode, 1'b0, 1'b0, 12'h000);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    // R9: reset holds outputs low while inputs are active
    mode = 2'd0; fval = 1'b1; lval = 1'b1; video = 12'hABC;
    repeat (3) @(negedge clk);
    chk("R9 pix",  int'(pix), 0);
    chk("R9 lval", int'(lo),  0);
    chk("R9 fval", int'(fo),  0);
    rst_ni = 1'b1;

    // R1, R2: live and reserved modes via vector table
    for (int i = 0; i < 8; i++) begin
      cyc(VEC[i][29:28], VEC[i][27], VEC[i][26], VEC[i][25:14]);
      chk("R1 live pix", int'(pix), int'(VEC[i][13:2]));
      chk("R2 lval",     int'(lo),  int'(VEC[i][1]));
      chk("R2 fval",     int'(fo),  int'(VEC[i][0]));
    end
    cyc(2'd0, 1'b0, 1'b0, 12'h000);

    // R3, R4: fixed ramp, full line plus overrun, repeated lines and frames
    cur_mode = 2'd1;
    frame_open();
    run_line(LP + 3, BASE);
    chk("R3 last code", int'(BASE + LP - 1), 2008);
    run_line(8, BASE);
    frame_close();
    frame_open();
    run_line(5, BASE);
    frame_close();

    // R6: sliding, first frame unshifted then +2 per frame
    cur_mode = 2'd2;
    cyc(cur_mode, 1'b0, 1'b0, 12'h000);
    for (int fr = 0; fr < 3; fr++) begin
      frame_open();
      run_line(4, BASE + 2 * fr);
      run_line(4, BASE + 2 * fr);
      frame_close();
    end

    // R8: leave sliding for one cycle, restart at base
    cur_mode = 2'd1;
    cyc(cur_mode, 1'b0, 1'b0, 12'h000);
    cur_mode = 2'd2;
    frame_open();
    run_line(4, BASE);
    frame_close();

    // R7: step to start 4094 and check the wrap
    for (int fr = 0; fr < 1566; fr++) begin
      frame_open();
      frame_close();
    end
    frame_open();
    run_line(4, 4094);
    chk("R7 wrap to zero", (4094 + 2) % 4096, 0);
    frame_close();

    // R1: reserved mode in a line passes video
    cur_mode = 2'd3;
    cyc(cur_mode, 1'b1, 1'b1, 12'h777);
    chk("R1 reserved", int'(pix), 12'h777);
    cyc(cur_mode, 1'b0, 1'b0, 12'h000);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule